// File: doc/BRIEF.md
# Dual-Channel CAN Transmit Redundancy Manager

This block sits between a host that wants a CAN frame sent and two independent CAN channel controllers. It chooses the physical channel for each pending transmission. In redundancy mode it watches how each attempt ends. If the active channel degrades into the error-passive condition, the block drops the request there and retries the same message on the other channel. No software takes part in this failover.

Each channel has its own health monitor. The monitor keeps a transmit error count from the controller's completion and failure pulses, and it reports whether the channel is still usable. A main sequencer uses those verdicts to pick the starting channel, to switch channels, or to give up when neither channel is usable. A free-running tick counter is captured whenever a switch happens or a transmission ends, so the host can measure failover latency. In normal mode the sequencer stays idle and the host request goes straight to channel 1.

Top module: `can_dual_tx_mgr`

## Requirements
- R1: With `redund_en` low, `tx_req[0]` follows `host_req` in the same cycle. `tx_req[1]`, `ch_sel` and all three strobes stay low, even when channel 1 reports a failure.
- R2: Each cycle with a failure pulse and no completion pulse on a channel raises that channel's error count by 8, saturating at 511. Each completion pulse without a failure pulse lowers it by 1, saturating at 0. Both counts are 0 after reset.
- R3: A channel becomes unusable when its error count goes above 128. It becomes usable again only once the count has fallen to 127 or below, so a count of exactly 128 keeps the current verdict.
- R4: In redundancy mode a host request starts on channel 1 if it is usable, otherwise on channel 2 if that is usable. If neither is usable, the failure strobe is pulsed and no channel request is raised.
- R5: If the active channel becomes unusable during a transmission, its request drops. The request moves to the other channel if that channel is usable; otherwise the failure strobe is pulsed.
- R6: `ch_sel` is 1 while channel 2 carries the transmission and 0 for channel 1. A raised request always matches `ch_sel`.
- R7: A completion on the active channel pulses `tx_ack` and `tx_ok` high for exactly one cycle each.
- R8: The failure strobe is one cycle long and never coincides with `tx_ok`.
- R9: A tick counter starts at 0 after reset and increments every cycle. `ts_latched` captures the tick value of the cycle in which a channel switch or a transmission end (success or failure) is decided, and it holds that value otherwise.
- R10: At most one channel request is high at a time. The request stays high until a result arrives on that channel or the channel becomes unusable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redund_en | input | 1 | 1 selects redundancy mode, 0 selects normal mode |
| host_req | input | 1 | Host transmit request (one-cycle pulse in redundancy mode) |
| chan_done | input | 2 | Per-channel transmission-complete pulse; bit 0 is channel 1 |
| chan_fail | input | 2 | Per-channel failed-attempt pulse; bit 0 is channel 1 |
| tx_req | output | 2 | Per-channel transmit request; bit 0 is channel 1 |
| ch_sel | output | 1 | Active channel: 0 = channel 1, 1 = channel 2 |
| tx_ack | output | 1 | One-cycle transmit acknowledge |
| tx_ok | output | 1 | One-cycle transmit success strobe |
| tx_fail_stb | output | 1 | One-cycle strobe when no usable channel is left |
| ts_latched | output | TS_W | Tick value captured at the last switch or transmission end |
| tec_ch1 | output | TEC_W | Channel 1 transmit error count |
| tec_ch2 | output | TEC_W | Channel 2 transmit error count |

## Verification
The assertions assume that `redund_en` stays constant while a transmission is in flight. They also assume that a channel controller never raises its done and fail pulses in the same cycle, and only answers while its request is high. The bench changes the mode only between transactions and holds each controller pulse for one cycle followed by a quiet cycle. It responds only to the channel whose request it sees, so the sequencer always gets a settled health verdict before the next result.

// File: rtl/can_red_pkg.sv
package can_red_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_CH,
    ST_WAIT,
    ST_SWITCH,
    ST_REQ_ALT,
    ST_DONE,
    ST_FAIL
  } red_state_e;

  typedef enum logic {
    MON_USABLE,
    MON_PASSIVE
  } mon_state_e;

endpackage

// File: rtl/can_ch_monitor.sv
module can_ch_monitor
  import can_red_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int FAIL_STEP   = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int RECOVER_LIM = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_done,
  input  logic             tx_fail,
  output logic [TEC_W-1:0] tec,
  output logic             usable
);

  localparam logic [TEC_W:0] STEP_W = (TEC_W+1)'(FAIL_STEP);

  function automatic logic [TEC_W-1:0] tec_raise(input logic [TEC_W-1:0] v);
    logic [TEC_W:0] sum;
    sum = {1'b0, v} + STEP_W;
    return sum[TEC_W] ? '1 : sum[TEC_W-1:0];
  endfunction

  function automatic logic [TEC_W-1:0] tec_lower(input logic [TEC_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [TEC_W-1:0] tec_q, tec_d;
  mon_state_e       mst_q, mst_d;

  always_comb begin
    tec_d = tec_q;
    if (tx_fail && !tx_done)      tec_d = tec_raise(tec_q);
    else if (tx_done && !tx_fail) tec_d = tec_lower(tec_q);
  end

  always_comb begin
    mst_d = mst_q;
    unique case (mst_q)
      MON_USABLE:  if (tec_d > TEC_W'(PASSIVE_LIM)) mst_d = MON_PASSIVE;
      MON_PASSIVE: if (tec_d <= TEC_W'(RECOVER_LIM)) mst_d = MON_USABLE;
      default:     mst_d = MON_USABLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      mst_q <= MON_USABLE;
    end else begin
      tec_q <= tec_d;
      mst_q <= mst_d;
    end
  end

  assign tec    = tec_q;
  assign usable = (mst_q == MON_USABLE);

endmodule

// File: rtl/can_red_main.sv
module can_red_main
  import can_red_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redund_en,
  input  logic            host_req,
  input  logic [1:0]      ch_usable,
  input  logic [1:0]      ch_done,
  output logic [1:0]      tx_req,
  output logic            ch_sel,
  output logic            tx_ack,
  output logic            tx_ok,
  output logic            tx_fail_stb,
  output logic [TS_W-1:0] ts_latched,
  output logic            ev_switch,
  output logic            ev_finish
);

  red_state_e      st_q, st_d;
  logic            cur_q, cur_d;
  logic [TS_W-1:0] tick_q;
  logic [TS_W-1:0] ts_q;
  logic            in_wait;

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    unique case (st_q)
      ST_IDLE:    if (redund_en && host_req) st_d = ST_REQ_CH;
      ST_REQ_CH: begin
        if (ch_usable[0]) begin
          cur_d = 1'b0;
          st_d  = ST_WAIT;
        end else if (ch_usable[1]) begin
          cur_d = 1'b1;
          st_d  = ST_WAIT;
        end else begin
          st_d  = ST_FAIL;
        end
      end
      ST_WAIT: begin
        if (ch_done[cur_q])         st_d = ST_DONE;
        else if (!ch_usable[cur_q]) st_d = ST_SWITCH;
      end
      ST_SWITCH: begin
        if (ch_usable[!cur_q]) begin
          cur_d = !cur_q;
          st_d  = ST_REQ_ALT;
        end else begin
          st_d  = ST_FAIL;
        end
      end
      ST_REQ_ALT: st_d = ST_WAIT;
      ST_DONE:    st_d = ST_IDLE;
      ST_FAIL:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  assign ev_switch = (st_q == ST_SWITCH);
  assign ev_finish = (st_q == ST_DONE) || (st_q == ST_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= 1'b0;
      tick_q <= '0;
      ts_q   <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      tick_q <= tick_q + 1'b1;
      if (ev_switch || ev_finish) ts_q <= tick_q;
    end
  end

  assign in_wait     = (st_q == ST_WAIT);
  assign tx_req[0]   = redund_en ? (in_wait && !cur_q) : host_req;
  assign tx_req[1]   = redund_en && in_wait && cur_q;
  assign ch_sel      = redund_en && cur_q;
  assign tx_ack      = (st_q == ST_DONE);
  assign tx_ok       = (st_q == ST_DONE);
  assign tx_fail_stb = (st_q == ST_FAIL);
  assign ts_latched  = ts_q;

endmodule

// File: rtl/can_dual_tx_mgr.sv
module can_dual_tx_mgr
  import can_red_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int TS_W        = 16,
  parameter int FAIL_STEP   = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int RECOVER_LIM = 127
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redund_en,
  input  logic            host_req,
  input  logic [1:0]      chan_done,
  input  logic [1:0]      chan_fail,
  output logic [1:0]      tx_req,
  output logic            ch_sel,
  output logic            tx_ack,
  output logic            tx_ok,
  output logic            tx_fail_stb,
  output logic [TS_W-1:0] ts_latched,
  output logic [TEC_W-1:0] tec_ch1,
  output logic [TEC_W-1:0] tec_ch2
);

  localparam int NCH = 2;

  logic [NCH-1:0]   ch_usable;
  logic [TEC_W-1:0] tec_arr [NCH];
  logic             ev_switch;
  logic             ev_finish;

  for (genvar g = 0; g < NCH; g++) begin : g_mon
    can_ch_monitor #(
      .TEC_W      (TEC_W),
      .FAIL_STEP  (FAIL_STEP),
      .PASSIVE_LIM(PASSIVE_LIM),
      .RECOVER_LIM(RECOVER_LIM)
    ) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .tx_done(chan_done[g]),
      .tx_fail(chan_fail[g]),
      .tec    (tec_arr[g]),
      .usable (ch_usable[g])
    );
  end

  can_red_main #(
    .TS_W(TS_W)
  ) u_main (
    .clk        (clk),
    .rst_n      (rst_n),
    .redund_en  (redund_en),
    .host_req   (host_req),
    .ch_usable  (ch_usable),
    .ch_done    (chan_done),
    .tx_req     (tx_req),
    .ch_sel     (ch_sel),
    .tx_ack     (tx_ack),
    .tx_ok      (tx_ok),
    .tx_fail_stb(tx_fail_stb),
    .ts_latched (ts_latched),
    .ev_switch  (ev_switch),
    .ev_finish  (ev_finish)
  );

  assign tec_ch1 = tec_arr[0];
  assign tec_ch2 = tec_arr[1];

endmodule

// File: rtl/can_dual_tx_mgr_chk.sv
module can_dual_tx_mgr_chk #(
  parameter int TEC_W       = 9,
  parameter int TS_W        = 16,
  parameter int FAIL_STEP   = 8,
  parameter int PASSIVE_LIM = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             redund_en,
  input logic [1:0]       chan_done,
  input logic [1:0]       chan_fail,
  input logic [1:0]       tx_req,
  input logic             ch_sel,
  input logic             tx_ok,
  input logic             tx_fail_stb,
  input logic [TS_W-1:0]  ts_latched,
  input logic [TEC_W-1:0] tec_ch1,
  input logic [TEC_W-1:0] tec_ch2,
  input logic [1:0]       ch_usable,
  input logic             ev_switch,
  input logic             ev_finish
);

  localparam logic [TEC_W-1:0] LIM_W  = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] STEP_W = TEC_W'(FAIL_STEP);
  localparam logic [TEC_W-1:0] ROOM_W = {TEC_W{1'b1}} - STEP_W;

  a_r10_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_req));

  a_r1_normal_ch1_only: assert property (@(posedge clk) disable iff (!rst_n)
    !redund_en |-> (!tx_req[1] && !ch_sel && !tx_ok && !tx_fail_stb));

  a_r2_fail_step: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_fail[0] && !chan_done[0] && tec_ch1 <= ROOM_W) |=> tec_ch1 == $past(tec_ch1) + STEP_W);

  a_r3_passive_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (tec_ch1 > LIM_W) |-> !ch_usable[0]);

  a_r3_passive_ch2: assert property (@(posedge clk) disable iff (!rst_n)
    (tec_ch2 > LIM_W) |-> !ch_usable[1]);

  a_r6_req_matches_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (redund_en && tx_req != 2'b00) |-> (tx_req[1] == ch_sel));

  a_r5_switch_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_switch && redund_en) |=> (tx_fail_stb || ch_sel != $past(ch_sel)));

  a_r7_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |=> !tx_ok);

  a_r8_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail_stb |=> !tx_fail_stb);

  a_r8_no_ok_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ok && tx_fail_stb));

  a_r9_ts_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_switch || ev_finish) |=> $stable(ts_latched));

endmodule

bind can_dual_tx_mgr can_dual_tx_mgr_chk #(
  .TEC_W      (TEC_W),
  .TS_W       (TS_W),
  .FAIL_STEP  (FAIL_STEP),
  .PASSIVE_LIM(PASSIVE_LIM)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .redund_en  (redund_en),
  .chan_done  (chan_done),
  .chan_fail  (chan_fail),
  .tx_req     (tx_req),
  .ch_sel     (ch_sel),
  .tx_ok      (tx_ok),
  .tx_fail_stb(tx_fail_stb),
  .ts_latched (ts_latched),
  .tec_ch1    (tec_ch1),
  .tec_ch2    (tec_ch2),
  .ch_usable  (ch_usable),
  .ev_switch  (ev_switch),
  .ev_finish  (ev_finish)
);

// File: tb/can_dual_tx_mgr_tb.sv
module can_dual_tx_mgr_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TEC_W      = 9;
  localparam int TS_W       = 16;
  localparam int TEC_MAX    = (1 << TEC_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             redund_en;
  logic             host_req;
  logic [1:0]       chan_done;
  logic [1:0]       chan_fail;
  logic [1:0]       tx_req;
  logic             ch_sel;
  logic             tx_ack;
  logic             tx_ok;
  logic             tx_fail_stb;
  logic [TS_W-1:0]  ts_latched;
  logic [TEC_W-1:0] tec_ch1;
  logic [TEC_W-1:0] tec_ch2;

  can_dual_tx_mgr #(.TEC_W(TEC_W), .TS_W(TS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .redund_en(redund_en), .host_req(host_req),
    .chan_done(chan_done), .chan_fail(chan_fail), .tx_req(tx_req),
    .ch_sel(ch_sel), .tx_ack(tx_ack), .tx_ok(tx_ok), .tx_fail_stb(tx_fail_stb),
    .ts_latched(ts_latched), .tec_ch1(tec_ch1), .tec_ch2(tec_ch2)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tb_cyc;
  always @(posedge clk) begin
    if (!rst_n) tb_cyc <= 0;
    else        tb_cyc <= tb_cyc + 1;
  end

  int n_chk  = 0;
  int n_fail = 0;

  int m_tec[2];
  bit m_use[2];
  int m_sel;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void m_fail(input int c);
    m_tec[c] = (m_tec[c] + 8 > TEC_MAX) ? TEC_MAX : m_tec[c] + 8;
    if (m_tec[c] > 128) m_use[c] = 1'b0;
  endfunction

  function automatic void m_done(input int c);
    if (m_tec[c] > 0) m_tec[c] = m_tec[c] - 1;
    if (m_tec[c] <= 127) m_use[c] = 1'b1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; redund_en = 1'b1; host_req = 1'b0;
    chan_done = 2'b00; chan_fail = 2'b00;
    m_tec[0] = 0; m_tec[1] = 0; m_use[0] = 1'b1; m_use[1] = 1'b1; m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Redundancy-mode transaction; the bench controller fails f0/f1 times per channel, then completes.
  task automatic run_txn(input string tag, input int f0, input int f1);
    int b[2];
    int c, exp_first, exp_fail, r[2], act_first, exp_ts, it;
    bit pulsed, prev_sel, seen;
    b[0] = f0; b[1] = f1;
    c = m_use[0] ? 0 : (m_use[1] ? 1 : -1);
    exp_first = c; exp_fail = (c < 0);
    if (c >= 0) m_sel = c;
    while (c >= 0) begin
      if (b[c] > 0) begin
        b[c]--; m_fail(c);
        if (!m_use[c]) begin
          if (m_use[1-c]) begin c = 1 - c; m_sel = c; end
          else begin exp_fail = 1; c = -1; end
        end
      end else begin
        m_done(c); c = -1;
      end
    end
    r[0] = f0; r[1] = f1; act_first = -1; pulsed = 0; seen = 0;
    prev_sel = ch_sel;
    @(negedge clk); host_req = 1'b1;
    @(negedge clk); host_req = 1'b0;
    for (it = 0; it < 4000; it++) begin
      if (it > 0) @(negedge clk);
      if (pulsed) begin chan_done = 2'b00; chan_fail = 2'b00; end
      if (tx_ok || tx_fail_stb) begin seen = 1; break; end
      if (ch_sel && !prev_sel && act_first >= 0)
        chk({tag, " R9 ts at switch"}, ts_latched, (tb_cyc - 1) % (1 << TS_W));
      prev_sel = ch_sel;
      if (pulsed) begin pulsed = 0; continue; end
      if (tx_req != 2'b00) begin
        c = tx_req[1] ? 1 : 0;
        if (act_first < 0) act_first = c;
        chk({tag, " R6 sel matches req"}, ch_sel, c);
        if (r[c] > 0) begin r[c]--; chan_fail[c] = 1'b1; end
        else chan_done[c] = 1'b1;
        pulsed = 1;
      end
    end
    chk({tag, " R10 result reached"}, seen, 1);
    chk({tag, " R4 first channel"}, act_first, exp_first);
    chk({tag, " R7 ok strobe"}, tx_ok, !exp_fail);
    chk({tag, " R7 ack strobe"}, tx_ack, !exp_fail);
    chk({tag, " R5 failure strobe"}, tx_fail_stb, exp_fail);
    exp_ts = tb_cyc % (1 << TS_W);
    @(negedge clk);
    chk({tag, " R7 ok one cycle"}, tx_ok | tx_ack, 0);
    chk({tag, " R8 fail one cycle"}, tx_fail_stb, 0);
    chk({tag, " R9 ts at end"}, ts_latched, exp_ts);
    chk({tag, " R6 final sel"}, ch_sel, m_sel);
    chk({tag, " R2 tec ch1"}, tec_ch1, m_tec[0]);
    chk({tag, " R2 tec ch2"}, tec_ch2, m_tec[1]);
  endtask

  // Normal-mode traffic on channel 1: n pulses of done or fail.
  task automatic run_normal(input string tag, input int n, input bit fail);
    redund_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_req = 1'b1;
      if (fail) chan_fail[0] = 1'b1; else chan_done[0] = 1'b1;
      #1;
      if (i == 0) begin
        chk({tag, " R1 req passthrough"}, tx_req, 2'b01);
        chk({tag, " R1 sel low"}, ch_sel, 0);
      end
      if (fail) m_fail(0); else m_done(0);
      @(negedge clk);
      host_req = 1'b0; chan_done = 2'b00; chan_fail = 2'b00;
      #1;
      if (i == 0) begin
        chk({tag, " R1 req follows low"}, tx_req, 2'b00);
        chk({tag, " R1 no strobes"}, {tx_ok, tx_ack, tx_fail_stb}, 0);
      end
    end
    @(negedge clk);
    chk({tag, " R1 sel low after"}, ch_sel, 0);
    chk({tag, " R2 tec ch1"}, tec_ch1, m_tec[0]);
    redund_en = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    chk("R2 reset tec ch1", tec_ch1, 0);
    chk("R2 reset tec ch2", tec_ch2, 0);
    chk("R10 reset req", tx_req, 0);
    chk("R6 reset sel", ch_sel, 0);
    chk("R8 reset strobes", {tx_ok, tx_ack, tx_fail_stb}, 0);
    chk("R9 reset ts", ts_latched, 0);

    // Sweep of failure counts on channel 1: 17 failures cross the 128 threshold.
    for (int k = 0; k <= 20; k++) begin
      do_reset();
      run_txn($sformatf("sweep k=%0d", k), k, 0);
    end

    // Both channels wear out: failure strobe, then immediate failure.
    do_reset();
    run_txn("both bad", 17, 17);
    run_txn("none usable R4", 0, 0);

    // Hysteresis: channel 1 back in service only at 127.
    do_reset();
    run_txn("wear ch1", 17, 0);
    run_normal("recover 8", 8, 1'b0);
    run_txn("at 128 R3 stays on ch2", 0, 0);
    run_normal("recover 1", 1, 1'b0);
    run_txn("at 127 R3 back on ch1", 0, 0);

    // Saturation at both ends and normal-mode failures.
    do_reset();
    run_normal("floor R2", 1, 1'b0);
    run_normal("ceiling R2", 64, 1'b1);
    run_normal("below ceiling R2", 1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule